// File: doc/BRIEF.md
# Word-Machine Effective Address and Field Unit

This unit takes one instruction word of a sign-magnitude machine and turns it into the two things an execution stage needs before it can start work. The first is the effective memory address. The second is a partial field of an operand word, shifted to the right end of a full word. A word is a sign and five 8-bit bytes. The instruction carries a signed two-byte address, an index selector, a modifier byte and an opcode byte. The unit adds the selected index register to the address, with signs respected. It then extracts the byte range named by the modifier from the operand word. Each problem found is reported on its own flag.

Requests arrive on a valid/ready input stream. Results leave on a valid/ready output stream, one register stage later. The output register holds a result until the consumer takes it. The input stream is ready whenever the output register is empty or is being emptied in the same cycle (`in_ready = !out_valid || out_ready`). Back-pressure therefore reaches the producer in the cycle it is applied, and a held result never changes.

Top module: `wm_addr_field`

## Requirements
- R1: For every accepted request, `opcode_o` equals instruction byte 5 (bits 7:0) and `mod_o` equals instruction byte 4 (bits 15:8).
- R2: Instruction word layout is as follows. Bit 40 is the sign (1 = negative), bits 39:24 are the address magnitude, bits 23:16 are the index selector, bits 15:8 are the modifier and bits 7:0 are the opcode. When the index selector is 0, `ea_o` (18-bit two's complement) equals the signed address.
- R3: When the index selector is 1 to 6, `ea_o` is the signed address plus index register n. Register n sits at `idx_regs_i[(n-1)*17 +: 17]`, with bit 16 as its sign and bits 15:0 as its magnitude. The addition is algebraic.
- R4: An index selector above 6 sets `idx_err_o`, and `ea_o` then equals the signed address with no index added.
- R5: `addr_err_o` is set exactly when `ea_o` is below 0 or above 3999.
- R6: The modifier is read as 8*L+R, with L in bits 7:3 and R in bits 2:0. Operand bytes max(L,1) through R are placed right-justified in `field_o` bits 39:0, and all other magnitude bits are zero. Operand bytes are numbered from 1 (the most significant, bits 39:32) to 5 (bits 7:0).
- R7: The sign of `field_o` (bit 40) copies the operand sign when L is 0, and is 0 (positive) otherwise.
- R8: When L > R or R > 5, `field_err_o` is set and `field_o` is all zero.
- R9: A request accepted at a rising edge gives `out_valid` high with its results after that same edge. `out_valid` never rises without an accepted request.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.
- R11: After reset, `out_valid` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| instr_i | input | 41 | Instruction word |
| idx_regs_i | input | 102 | Six index registers, each a sign and 16-bit magnitude |
| opnd_i | input | 41 | Operand word for field extraction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| ea_o | output | 18 | Effective address, two's complement |
| field_o | output | 41 | Extracted field, sign in bit 40 |
| mod_o | output | 8 | Modifier byte |
| opcode_o | output | 8 | Opcode byte |
| idx_err_o | output | 1 | Index selector above 6 |
| addr_err_o | output | 1 | Effective address outside 0..3999 |
| field_err_o | output | 1 | Malformed field range |

## Verification
The properties assume a well-behaved producer. It keeps `instr_i`, `idx_regs_i` and `opnd_i` meaningful only in the cycle a request is accepted. It also never raises `out_ready` in a way that depends on `in_ready`. The bench drives a fresh request only on a falling edge, drops `in_valid` right after acceptance, and changes `out_ready` only between requests. Random instructions are biased toward small address and index magnitudes, so that both in-range and out-of-range addresses occur. Random modifiers mix legal ranges with the L > R and R > 5 cases.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int WM_BYTE_W    = 8;
  localparam int WM_NBYTES    = 5;
  localparam int WM_NIDX      = 6;
  localparam int WM_MEM_WORDS = 4000;

  typedef struct packed {
    logic idx;
    logic addr;
    logic field;
  } wm_err_t;
endpackage

// File: rtl/wm_ea_calc.sv
module wm_ea_calc #(
  parameter int BYTE_W    = 8,
  parameter int NIDX      = 6,
  parameter int MEM_WORDS = 4000
) (
  input  logic                        a_neg,
  input  logic [2*BYTE_W-1:0]         a_mag,
  input  logic [BYTE_W-1:0]           idx_sel,
  input  logic [NIDX*(2*BYTE_W+1)-1:0] idx_flat,
  output logic signed [2*BYTE_W+1:0]  ea,
  output logic                        idx_err,
  output logic                        addr_err
);
  localparam int IDX_W = 2*BYTE_W + 1;
  localparam int EA_W  = 2*BYTE_W + 2;
  localparam logic signed [EA_W-1:0] LIMIT = EA_W'(MEM_WORDS);

  logic signed [EA_W-1:0] ival [NIDX+1];
  logic signed [EA_W-1:0] base, off;

  assign ival[0] = '0;
  for (genvar g = 0; g < NIDX; g++) begin : g_idx
    logic               s;
    logic [2*BYTE_W-1:0] m;
    assign s = idx_flat[g*IDX_W + IDX_W - 1];
    assign m = idx_flat[g*IDX_W +: 2*BYTE_W];
    assign ival[g+1] = s ? -$signed({2'b00, m}) : $signed({2'b00, m});
  end

  always_comb begin
    idx_err = (int'(idx_sel) > NIDX);
    base    = a_neg ? -$signed({2'b00, a_mag}) : $signed({2'b00, a_mag});
    off     = '0;
    for (int j = 0; j <= NIDX; j++)
      if (int'(idx_sel) == j) off = ival[j];
    ea       = base + off;
    addr_err = (ea < 0) || (ea >= LIMIT);
  end
endmodule

// File: rtl/wm_field_extract.sv
module wm_field_extract #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 5
) (
  input  logic [NBYTES*BYTE_W:0] opnd,
  input  logic [BYTE_W-1:0]      fspec,
  output logic [NBYTES*BYTE_W:0] res,
  output logic                   field_err
);
  localparam int MAG_W = NBYTES*BYTE_W;

  int              l_i, r_i, lo_i;
  logic [MAG_W-1:0] masked, shifted;

  always_comb begin
    l_i  = int'(fspec[BYTE_W-1:3]);
    r_i  = int'(fspec[2:0]);
    lo_i = (l_i == 0) ? 1 : l_i;
    field_err = (l_i > r_i) || (r_i > NBYTES);
  end

  for (genvar k = 1; k <= NBYTES; k++) begin : g_byte
    assign masked[(NBYTES-k)*BYTE_W +: BYTE_W] =
      ((k >= lo_i) && (k <= r_i)) ? opnd[(NBYTES-k)*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    shifted = (r_i > NBYTES) ? '0 : (masked >> ((NBYTES - r_i) * BYTE_W));
    if (field_err) res = '0;
    else           res = {(l_i == 0) ? opnd[MAG_W] : 1'b0, shifted};
  end
endmodule

// File: rtl/wm_addr_field.sv
module wm_addr_field
  import wm_pkg::*;
#(
  parameter int BYTE_W    = WM_BYTE_W,
  parameter int NBYTES    = WM_NBYTES,
  parameter int NIDX      = WM_NIDX,
  parameter int MEM_WORDS = WM_MEM_WORDS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [NBYTES*BYTE_W:0]        instr_i,
  input  logic [NIDX*(2*BYTE_W+1)-1:0]  idx_regs_i,
  input  logic [NBYTES*BYTE_W:0]        opnd_i,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [2*BYTE_W+1:0]           ea_o,
  output logic [NBYTES*BYTE_W:0]        field_o,
  output logic [BYTE_W-1:0]             mod_o,
  output logic [BYTE_W-1:0]             opcode_o,
  output logic                          idx_err_o,
  output logic                          addr_err_o,
  output logic                          field_err_o
);
  localparam int WORD_W  = NBYTES*BYTE_W + 1;
  localparam int EA_W    = 2*BYTE_W + 2;
  localparam int OPC_LSB = 0;
  localparam int MOD_LSB = BYTE_W;
  localparam int IDX_LSB = 2*BYTE_W;
  localparam int ADR_LSB = (NBYTES-2)*BYTE_W;

  logic signed [EA_W-1:0] ea_c;
  logic [WORD_W-1:0]      field_c;
  wm_err_t                err_c, err_q;
  logic                   accept;

  wm_ea_calc #(.BYTE_W(BYTE_W), .NIDX(NIDX), .MEM_WORDS(MEM_WORDS)) ea_i (
    .a_neg    (instr_i[WORD_W-1]),
    .a_mag    (instr_i[ADR_LSB +: 2*BYTE_W]),
    .idx_sel  (instr_i[IDX_LSB +: BYTE_W]),
    .idx_flat (idx_regs_i),
    .ea       (ea_c),
    .idx_err  (err_c.idx),
    .addr_err (err_c.addr)
  );

  wm_field_extract #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) fx_i (
    .opnd      (opnd_i),
    .fspec     (instr_i[MOD_LSB +: BYTE_W]),
    .res       (field_c),
    .field_err (err_c.field)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea_o      <= '0;
      field_o   <= '0;
      mod_o     <= '0;
      opcode_o  <= '0;
      err_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      ea_o      <= ea_c;
      field_o   <= field_c;
      mod_o     <= instr_i[MOD_LSB +: BYTE_W];
      opcode_o  <= instr_i[OPC_LSB +: BYTE_W];
      err_q     <= err_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign idx_err_o   = err_q.idx;
  assign addr_err_o  = err_q.addr;
  assign field_err_o = err_q.field;
endmodule

// File: rtl/wm_addr_field_chk.sv
module wm_addr_field_chk #(
  parameter int BYTE_W    = 8,
  parameter int NBYTES    = 5,
  parameter int NIDX      = 6,
  parameter int MEM_WORDS = 4000
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic [NBYTES*BYTE_W:0]        instr_i,
  input logic [NIDX*(2*BYTE_W+1)-1:0]  idx_regs_i,
  input logic [NBYTES*BYTE_W:0]        opnd_i,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [2*BYTE_W+1:0]           ea_o,
  input logic [NBYTES*BYTE_W:0]        field_o,
  input logic [BYTE_W-1:0]             mod_o,
  input logic [BYTE_W-1:0]             opcode_o,
  input logic                          idx_err_o,
  input logic                          addr_err_o,
  input logic                          field_err_o
);
  localparam int WORD_W = NBYTES*BYTE_W + 1;
  localparam int EA_W   = 2*BYTE_W + 2;

  logic acc;
  int   f_l, f_r, sel;
  assign acc = in_valid && in_ready;
  assign f_l = int'(instr_i[2*BYTE_W-1:BYTE_W+3]);
  assign f_r = int'(instr_i[BYTE_W+2:BYTE_W]);
  assign sel = int'(instr_i[2*BYTE_W +: BYTE_W]);

  AST_OPCODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> opcode_o == $past(instr_i[BYTE_W-1:0]));                // R1
  AST_IDX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel > NIDX) |=> idx_err_o);                             // R4
  AST_ADDR_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !addr_err_o) |-> (!ea_o[EA_W-1] && int'(ea_o) < MEM_WORDS)); // R5
  AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mod_o[BYTE_W-1:3] != '0) |-> !field_o[WORD_W-1]); // R7
  AST_FIELD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (f_l > f_r || f_r > NBYTES)) |=> (field_err_o && field_o == '0)); // R8
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);                                             // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc));                               // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(ea_o) && $stable(field_o)
                                   && $stable(opcode_o) && $stable(mod_o))); // R10
endmodule

bind wm_addr_field wm_addr_field_chk #(
  .BYTE_W(BYTE_W), .NBYTES(NBYTES), .NIDX(NIDX), .MEM_WORDS(MEM_WORDS)
) chk_i (.*);

// File: tb/wm_addr_field_tb_top.sv
module wm_addr_field_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [40:0]  instr_i = '0;
  logic [101:0] idx_regs_i = '0;
  logic [40:0]  opnd_i = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [17:0]  ea_o;
  logic [40:0]  field_o;
  logic [7:0]   mod_o, opcode_o;
  logic         idx_err_o, addr_err_o, field_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wm_addr_field dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ea(input logic [40:0] ins, input logic [101:0] ir);
    int a, sel, o;
    a   = int'(ins[39:24]);
    if (ins[40]) a = -a;
    sel = int'(ins[23:16]);
    o   = 0;
    if (sel >= 1 && sel <= 6) begin
      o = int'(ir[(sel-1)*17 +: 16]);
      if (ir[(sel-1)*17 + 16]) o = -o;
    end
    return a + o;
  endfunction

  function automatic logic [40:0] exp_field(input logic [7:0] f, input logic [40:0] op);
    int l, r, lo;
    logic [39:0] m;
    l = int'(f[7:3]); r = int'(f[2:0]);
    if (l > r || r > 5) return '0;
    lo = (l == 0) ? 1 : l;
    m = '0;
    for (int k = lo; k <= r; k++) m = {m[31:0], op[(5-k)*8 +: 8]};
    return {(l == 0) ? op[40] : 1'b0, m};
  endfunction

  task automatic run(input logic [40:0] ins, input logic [101:0] ir,
                     input logic [40:0] op, input bit stall);
    int e;
    logic [40:0] fe;
    logic [17:0] ea_h;
    @(negedge clk);
    instr_i = ins; idx_regs_i = ir; opnd_i = op;
    in_valid = 1'b1; out_ready = !stall;
    @(negedge clk);
    in_valid = 1'b0;
    e  = exp_ea(ins, ir);
    fe = exp_field(ins[15:8], op);
    chk(out_valid == 1'b1, "R9 out_valid", out_valid, 1);
    chk(opcode_o == ins[7:0] && mod_o == ins[15:8], "R1 opcode/mod",
        {mod_o, opcode_o}, ins[15:0]);
    if (int'(ins[23:16]) == 0)
      chk(int'($signed(ea_o)) == e, "R2 direct ea", int'($signed(ea_o)), e);
    else if (int'(ins[23:16]) <= 6)
      chk(int'($signed(ea_o)) == e, "R3 indexed ea", int'($signed(ea_o)), e);
    else begin
      chk(idx_err_o == 1'b1, "R4 idx_err", idx_err_o, 1);
      chk(int'($signed(ea_o)) == e, "R4 ea ignores index", int'($signed(ea_o)), e);
    end
    if (int'(ins[23:16]) <= 6) chk(idx_err_o == 1'b0, "R4 idx_err clear", idx_err_o, 0);
    chk(addr_err_o == (e < 0 || e > 3999), "R5 addr_err", addr_err_o, (e < 0 || e > 3999));
    chk(field_o[39:0] == fe[39:0], "R6 field magnitude", field_o[39:0], fe[39:0]);
    chk(field_o[40] == fe[40], "R7 field sign", field_o[40], fe[40]);
    chk(field_err_o == (ins[15:11] > {2'b0, ins[10:8]} || ins[10:8] > 3'd5),
        "R8 field_err", field_err_o, 0);
    if (stall) begin
      ea_h = ea_o;
      repeat (2) begin
        @(negedge clk);
        chk(out_valid && !in_ready && ea_o == ea_h && field_o == fe,
            "R10 hold under back-pressure", {out_valid, in_ready}, 2);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 release", out_valid, 0);
    end
  endtask

  function automatic logic [40:0] mk(input bit s, input int a, input int ix, input int l,
                                      input int r, input int c);
    return {s, a[15:0], ix[7:0], l[4:0], r[2:0], c[7:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [101:0] ir;
    logic [40:0]  op;
    void'($urandom(32'd7319));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && ea_o == 0 && field_o == 0 && opcode_o == 0 && !idx_err_o
        && !addr_err_o && !field_err_o, "R11 reset state", out_valid, 0);
    rst_n = 1'b1;

    ir = '0;
    ir[0*17 +: 17] = {1'b0, 16'd100};
    ir[1*17 +: 17] = {1'b1, 16'd50};
    ir[5*17 +: 17] = {1'b0, 16'd3999};
    op = {1'b1, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    run(mk(0, 1234, 0, 0, 5, 8), ir, op, 0);   // R2 whole word
    run(mk(1, 5,    0, 0, 0, 9), ir, op, 0);   // R2 negative, R5, sign only
    run(mk(0, 3899, 1, 1, 5, 1), ir, op, 0);   // R3 -> 3999
    run(mk(0, 3900, 1, 4, 4, 2), ir, op, 0);   // R3 -> 4000, R5
    run(mk(0, 50,   2, 4, 5, 3), ir, op, 1);   // R3 negative index -> 0, R10
    run(mk(1, 1,    6, 3, 3, 4), ir, op, 0);   // R3 -> 3998
    run(mk(0, 77,   7, 0, 2, 5), ir, op, 0);   // R4
    run(mk(0, 10,   200, 3, 2, 6), ir, op, 0); // R4, R8 L>R
    run(mk(0, 10,   0, 0, 6, 7), ir, op, 1);   // R8 R>5, R10
    run(mk(0, 10,   0, 2, 2, 8), ir, op, 0);   // R6 single byte

    for (int t = 0; t < 300; t++) begin
      logic [40:0] ins;
      int l, r, a;
      for (int g = 0; g < 6; g++)
        ir[g*17 +: 17] = {1'($urandom), 16'($urandom % 3000)};
      op = {1'($urandom), 40'({$urandom, $urandom})};
      l = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 6);
      r = ($urandom % 4 == 0) ? int'($urandom % 8) : l + int'($urandom % (6 - (l > 5 ? 5 : l)));
      if (r > 7) r = 7;
      a = ($urandom % 8 == 0) ? int'($urandom % 65536) : int'($urandom % 5000);
      ins = mk(1'($urandom % 5 == 0), a, int'($urandom % 9), l, r, int'($urandom % 256));
      run(ins, ir, op, ($urandom % 6) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule